// File: doc/BRIEF.md
# Halfword Load Address and Alignment Unit

This unit carries the data path of a sign-extending halfword load for a core that runs either byte order and either a 32-bit or a 64-bit register mode. From the instruction word it takes the base register index, the destination register index and a 16-bit displacement. It adds the displacement to the supplied base value, steers the request to memory and picks the right 16 bits out of the aligned doubleword that memory returns.

The memory request side is combinational. The physical address equals the virtual address except for a reversible lane swap in bits 2:1. The lane that holds the halfword depends on the big-endian setting. The writeback side is registered: the sign-extended result, its destination index and the error flag appear one clock after the request. Address translation is an identity map, and the uncached attribute is always 0.

Top module: `lh_unit`

## Requirements
- R1: A load is recognised only when `valid_i` is 1 and `instr_i[31:26]` equals 6'b100001. For any other word, `mem_req_o`, `addr_err_o` and `wb_en_o` stay 0.
- R2: `vaddr_o` is registered, one cycle after the inputs. In 64-bit mode it is the 16-bit displacement `instr_i[15:0]` sign-extended to 64 bits plus `base_i`. In 32-bit mode it is the low 32 bits of that sum, with bits 63:32 forced to 0.
- R3: For a recognised load whose virtual address has bit 0 set, `addr_err_o` is 1 in the following cycle, `wb_en_o` is 0, and `mem_req_o` is 0 in the request cycle.
- R4: `paddr_o` keeps virtual address bits 63:3 and bit 0. Bits 2:1 are XORed with `rev_endian_i` on both bits.
- R5: The lane index is virtual address bits 2:0 XOR {`big_endian_i`, `big_endian_i`, 0}. The halfword is `mem_data_i[8*lane+15 : 8*lane]`.
- R6: In 64-bit mode the result on `wb_data_o` is the selected halfword, sign-extended by copying its bit 15 into bits 63:16.
- R7: In 32-bit mode the result is sign-extended to 32 bits, and `wb_data_o[63:32]` is 0.
- R8: `wb_en_o` is 1 one cycle after an aligned recognised load whose destination index `instr_i[20:16]` is nonzero. `wb_idx_o` then carries that index. A destination index of 0 suppresses `wb_en_o`.
- R9: While `mem_req_o` is 1, `mem_size_o` is the halfword code 2'b01 and `mem_uncached_o` is 0.
- R10: While `rst_ni` is low, all registered outputs are 0.
- R11: `base_idx_o` equals `instr_i[25:21]` combinationally, so the register file can return `base_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word is valid |
| instr_i | input | 32 | Instruction word |
| base_i | input | 64 | Base register value |
| mode64_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| big_endian_i | input | 1 | Core runs big-endian |
| rev_endian_i | input | 1 | Reverse the byte order seen at memory |
| mem_data_i | input | 64 | Aligned doubleword returned by memory |
| base_idx_o | output | 5 | Base register index for register read |
| mem_req_o | output | 1 | Memory read request |
| paddr_o | output | 64 | Physical address |
| mem_size_o | output | 2 | Access size code |
| mem_uncached_o | output | 1 | Uncached attribute |
| vaddr_o | output | 64 | Registered virtual address |
| addr_err_o | output | 1 | Misaligned address error |
| wb_en_o | output | 1 | Register writeback enable |
| wb_idx_o | output | 5 | Writeback register index |
| wb_data_o | output | 64 | Sign-extended load result |

## Verification
The request outputs `mem_req_o`, `paddr_o`, `mem_size_o`, `mem_uncached_o` and `base_idx_o` depend only on the current inputs. They are checked 1 ns after each stimulus is driven on a falling edge. The writeback outputs `vaddr_o`, `addr_err_o`, `wb_en_o`, `wb_idx_o` and `wb_data_o` come one rising edge after the stimulus. The driver queues their expected values, and the monitor compares them on the next falling edge. One stimulus per cycle keeps each queue entry matched to exactly one register update.

// File: rtl/lh_pkg.sv
package lh_pkg;
  localparam logic [5:0] OPC_LH = 6'b100001;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } mem_size_e;

  typedef struct packed {
    logic        is_lh;
    logic [4:0]  base_idx;
    logic [4:0]  dst_idx;
    logic [15:0] disp;
  } lh_dec_t;
endpackage

// File: rtl/lh_decode.sv
module lh_decode
  import lh_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output lh_dec_t     dec_o
);
  always_comb begin
    dec_o.is_lh    = valid_i && (instr_i[31:26] == OPC_LH);
    dec_o.base_idx = instr_i[25:21];
    dec_o.dst_idx  = instr_i[20:16];
    dec_o.disp     = instr_i[15:0];
  end
endmodule

// File: rtl/lh_agen.sv
module lh_agen #(
  parameter int XLEN = 64,
  parameter int DW   = 16
) (
  input  logic [DW-1:0]   disp_i,
  input  logic [XLEN-1:0] base_i,
  input  logic            mode64_i,
  input  logic            rev_endian_i,
  output logic [XLEN-1:0] vaddr_o,
  output logic [XLEN-1:0] paddr_o,
  output logic            misaligned_o
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] sum;

  always_comb begin
    disp_ext = {{(XLEN-DW){disp_i[DW-1]}}, disp_i};
    sum      = disp_ext + base_i;
    // narrow mode: low half only; 16-copy extension gives the same low bits
    vaddr_o  = mode64_i ? sum : {{(XLEN-HALF){1'b0}}, sum[HALF-1:0]};
    paddr_o  = {vaddr_o[XLEN-1:3], vaddr_o[2:1] ^ {2{rev_endian_i}}, vaddr_o[0]};
    misaligned_o = vaddr_o[0];
  end
endmodule

// File: rtl/lh_lane_sel.sv
module lh_lane_sel #(
  parameter int XLEN = 64,
  parameter int HW   = 16
) (
  input  logic [XLEN-1:0] mem_data_i,
  input  logic [2:1]      va_lo_i,
  input  logic            big_endian_i,
  input  logic            mode64_i,
  output logic [XLEN-1:0] result_o
);
  localparam int NSLOT = XLEN / HW;
  localparam int SW    = $clog2(NSLOT);
  localparam int HALF  = XLEN / 2;

  logic [HW-1:0] slot_q [NSLOT];
  logic [SW-1:0] slot;
  logic [HW-1:0] hw;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign slot_q[i] = mem_data_i[i*HW +: HW];
  end

  always_comb begin
    slot = va_lo_i ^ {SW{big_endian_i}};
    hw   = slot_q[slot];
    if (mode64_i) result_o = {{(XLEN-HW){hw[HW-1]}}, hw};
    else          result_o = {{(XLEN-HALF){1'b0}}, {(HALF-HW){hw[HW-1]}}, hw};
  end
endmodule

// File: rtl/lh_unit.sv
module lh_unit
  import lh_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] base_i,
  input  logic            mode64_i,
  input  logic            big_endian_i,
  input  logic            rev_endian_i,
  input  logic [XLEN-1:0] mem_data_i,
  output logic [4:0]      base_idx_o,
  output logic            mem_req_o,
  output logic [XLEN-1:0] paddr_o,
  output logic [1:0]      mem_size_o,
  output logic            mem_uncached_o,
  output logic [XLEN-1:0] vaddr_o,
  output logic            addr_err_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_data_o
);
  localparam int HALF = XLEN / 2;

  lh_dec_t         dec;
  logic [XLEN-1:0] vaddr;
  logic            misaligned;
  logic [XLEN-1:0] result;

  lh_decode u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  lh_agen #(.XLEN(XLEN), .DW(16)) u_agen (
    .disp_i       (dec.disp),
    .base_i       (base_i),
    .mode64_i     (mode64_i),
    .rev_endian_i (rev_endian_i),
    .vaddr_o      (vaddr),
    .paddr_o      (paddr_o),
    .misaligned_o (misaligned)
  );

  lh_lane_sel #(.XLEN(XLEN), .HW(16)) u_sel (
    .mem_data_i   (mem_data_i),
    .va_lo_i      (vaddr[2:1]),
    .big_endian_i (big_endian_i),
    .mode64_i     (mode64_i),
    .result_o     (result)
  );

  assign base_idx_o     = dec.base_idx;
  assign mem_req_o      = dec.is_lh && !misaligned;
  assign mem_size_o     = SZ_HALF;
  assign mem_uncached_o = 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_o    <= '0;
      addr_err_o <= 1'b0;
      wb_en_o    <= 1'b0;
      wb_idx_o   <= '0;
      wb_data_o  <= '0;
    end else begin
      vaddr_o    <= vaddr;
      addr_err_o <= dec.is_lh && misaligned;
      wb_en_o    <= dec.is_lh && !misaligned && (dec.dst_idx != 5'd0);
      wb_idx_o   <= dec.dst_idx;
      wb_data_o  <= result;
    end
  end

  a_r3_err_blocks_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !wb_en_o);
  a_r8_no_wb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o != 5'd0));
  a_r4_req_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !paddr_o[0]);
  a_r7_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && !$past(mode64_i)) |-> (wb_data_o[XLEN-1:HALF] == '0));
  a_r6_wide_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && $past(mode64_i)) |-> ((&wb_data_o[XLEN-1:15]) || !(|wb_data_o[XLEN-1:15])));
  a_r1_no_req_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> !$past(mem_req_o));
endmodule

// File: tb/lh_unit_test.sv
module lh_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] base_i = '0;
  logic        mode64_i = 1'b0;
  logic        big_endian_i = 1'b0;
  logic        rev_endian_i = 1'b0;
  logic [63:0] mem_data_i = '0;
  logic [4:0]  base_idx_o;
  logic        mem_req_o;
  logic [63:0] paddr_o;
  logic [1:0]  mem_size_o;
  logic        mem_uncached_o;
  logic [63:0] vaddr_o;
  logic        addr_err_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic [63:0] wb_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] vaddr;
    logic        err;
    logic        wb;
    logic [4:0]  idx;
    logic [63:0] data;
  } exp_t;
  exp_t q[$];

  always #4 clk_i = ~clk_i;

  lh_unit uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [15:0] off);
    return {op, rs, rt, off};
  endfunction

  task automatic drive(input logic v, input logic [31:0] ins, input logic [63:0] base,
                       input logic m64, input logic be, input logic re, input logic [63:0] mem);
    logic        is_lh, err, req;
    logic [63:0] sum, pa, data;
    logic [2:0]  lane;
    logic [15:0] hw;
    exp_t        e;
    @(negedge clk_i);
    valid_i = v; instr_i = ins; base_i = base; mode64_i = m64;
    big_endian_i = be; rev_endian_i = re; mem_data_i = mem;
    is_lh = v && (ins[31:26] == 6'b100001);
    sum = {{48{ins[15]}}, ins[15:0]} + base;
    if (!m64) sum = {32'h0, sum[31:0]};
    err  = is_lh && sum[0];
    req  = is_lh && !sum[0];
    pa   = {sum[63:3], sum[2:0] ^ {re, re, 1'b0}};
    lane = (sum[2:0] ^ {be, be, 1'b0}) & 3'b110;
    hw   = mem[lane*8 +: 16];
    data = m64 ? {{48{hw[15]}}, hw} : {32'h0, {16{hw[15]}}, hw};
    #1;
    chk(mem_req_o == req, "R1/R3 mem_req", 64'(mem_req_o), 64'(req));
    chk(base_idx_o == ins[25:21], "R11 base_idx", 64'(base_idx_o), 64'(ins[25:21]));
    if (req) begin
      chk(paddr_o == pa, "R4 paddr", paddr_o, pa);
      chk(mem_size_o == 2'b01 && !mem_uncached_o, "R9 size/uncached",
          {61'h0, mem_uncached_o, mem_size_o}, 64'h1);
    end
    e.vaddr = sum; e.err = err; e.wb = req && (ins[20:16] != 5'd0);
    e.idx = ins[20:16]; e.data = data;
    q.push_back(e);
  endtask

  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(vaddr_o == e.vaddr, "R2 vaddr", vaddr_o, e.vaddr);
      chk(addr_err_o == e.err, "R3 addr_err", 64'(addr_err_o), 64'(e.err));
      chk(wb_en_o == e.wb, "R8 wb_en", 64'(wb_en_o), 64'(e.wb));
      if (e.wb) begin
        chk(wb_idx_o == e.idx, "R8 wb_idx", 64'(wb_idx_o), 64'(e.idx));
        chk(wb_data_o == e.data, "R5/R6/R7 wb_data", wb_data_o, e.data);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp=%h", 64'h0, 64'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] mem;
    mem = 64'h8765_F00F_4321_9ABC;
    repeat (3) @(negedge clk_i);
    // R10: registered outputs held at zero in reset
    chk(vaddr_o == 0 && !addr_err_o && !wb_en_o && wb_idx_o == 0 && wb_data_o == 0,
        "R10 reset", wb_data_o | vaddr_o, 64'h0);
    rst_ni = 1'b1;
    // sweep lanes, byte orders, reverse setting and modes (R4 R5 R6 R7)
    for (int m = 0; m < 2; m++)
      for (int be = 0; be < 2; be++)
        for (int re = 0; re < 2; re++)
          for (int l = 0; l < 4; l++) begin
            logic [15:0] off;
            off = ((l + re) % 2 == 0) ? 16'(l * 2) : (16'hFFF0 | 16'(l * 2));
            drive(1'b1, mk(6'b100001, 5'd3, 5'(l + 1), off), 64'h0000_0012_3456_7000,
                  1'(m), 1'(be), 1'(re), mem);
          end
    // R3 odd address, both modes
    drive(1'b1, mk(6'b100001, 5'd2, 5'd7, 16'h0003), 64'h1000, 1'b1, 1'b0, 1'b0, mem);
    drive(1'b1, mk(6'b100001, 5'd2, 5'd7, 16'hFFFF), 64'h1000, 1'b0, 1'b1, 1'b1, mem);
    // R1 wrong opcode and invalid slot
    drive(1'b1, mk(6'b100011, 5'd2, 5'd7, 16'h0002), 64'h1000, 1'b1, 1'b0, 1'b0, mem);
    drive(1'b0, mk(6'b100001, 5'd2, 5'd7, 16'h0002), 64'h1000, 1'b1, 1'b0, 1'b0, mem);
    drive(1'b1, mk(6'b100001, 5'd2, 5'd7, 16'h0001), 64'h1000, 1'b1, 1'b0, 1'b0, 64'h0);
    // R8 destination zero suppressed
    drive(1'b1, mk(6'b100001, 5'd4, 5'd0, 16'h0004), 64'h2000, 1'b1, 1'b0, 1'b0, mem);
    // R2 wrap in 32-bit mode vs carry in 64-bit mode
    drive(1'b1, mk(6'b100001, 5'd5, 5'd9, 16'h0004), 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b0, 1'b0, mem);
    drive(1'b1, mk(6'b100001, 5'd5, 5'd9, 16'h0004), 64'h0000_0000_FFFF_FFFE, 1'b1, 1'b0, 1'b0, mem);
    // R6 R7 positive halfwords
    drive(1'b1, mk(6'b100001, 5'd6, 5'd31, 16'h0000), 64'h40, 1'b1, 1'b0, 1'b0, 64'h1111_2222_3333_7FFF);
    drive(1'b1, mk(6'b100001, 5'd6, 5'd31, 16'h0000), 64'h40, 1'b0, 1'b1, 1'b0, 64'h7FFE_2222_3333_8000);
    drive(1'b0, 32'h0, 64'h0, 1'b0, 1'b0, 1'b0, 64'h0);
    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule